// File: doc/BRIEF.md
# Shifting DMA Completion Queue with Status Flags

This block keeps the bookkeeping for jobs that a DMA engine has accepted but not yet retired. Every accepted job takes the next free slot at the tail of a small queue. The slot stores the job's tag, queue identifier and descriptor address, plus a flag that says a status record is still owed for that job. The data mover reports finished jobs by tag. A finished job whose flag is set becomes a candidate for the status output. That output is a valid/ready channel that carries the tag, the queue identifier and the address.

After a record has been handed over, the flag of the slot it came from is cleared one cycle later. A slot leaves the queue only from the head, and only once it is finished and its flag is clear. When the head leaves, every slot moves one place toward the head. The pending flag clear can land in the same cycle as that move. The block then applies the clear to the slot before the move, so the clear follows the job to its new place. No job is ever reported twice.

Top module: `cq_status_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0 and `st_valid` is 0.
- R2: A request with `alloc_valid` high and `full` low is accepted at the clock edge and appends one slot at the tail. The slot's status flag is set only when `alloc_ser` is 1. The number of held slots changes by at most one per cycle.
- R3: `full` is 1 exactly when all DEPTH slots are held. A request made while `full` is 1 is dropped and never produces a status record.
- R4: A slot cannot offer a status record before a `done_valid` pulse carrying its tag has been taken.
- R5: The channel offers one record per cycle. The record comes from the oldest held slot that is finished, has its flag set and is not already sent.
- R6: The offered record carries the tag, queue identifier and address that were given at allocation.
- R7: A record accepted with `st_valid` and `st_ready` high is never offered again. Each job with its flag set produces exactly one record.
- R8: A job allocated with `alloc_ser` 0 produces no record. Once it is finished, it leaves the queue when it reaches the head.
- R9: The flag clear that follows a send stays with its job when the head leaves in the same cycle as the send, or in the cycle of the clear.
- R10: A `done_valid` pulse whose tag matches no held slot changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate a slot for a new job |
| alloc_ser | input | 1 | The new job wants a status record |
| alloc_tag | input | TAGW | Tag of the new job, unique among held slots |
| alloc_qid | input | QIDW | Queue identifier of the new job |
| alloc_addr | input | AW | Descriptor address of the new job |
| full | output | 1 | All slots held; allocation refused |
| done_valid | input | 1 | The data mover finished the job named by done_tag |
| done_tag | input | TAGW | Tag of the finished job |
| st_valid | output | 1 | A status record is offered |
| st_ready | input | 1 | The consumer takes the offered record |
| st_tag | output | TAGW | Tag in the offered record |
| st_qid | output | QIDW | Queue identifier in the offered record |
| st_addr | output | AW | Descriptor address in the offered record |

## Verification
The risky overlap is a head removal that falls in the same cycle as a status send, or in the cycle of the flag clear that follows the send. Directed sequences create both cases. A job whose flag is clear sits at the head and a flagged job sits behind it. The bench then times the head's completion and the consumer's ready so that the move lands on the send cycle in one case and on the clear cycle in the other. The bench judges the result at the output: after the overlap the channel must go quiet and must not offer the sent job again. Random phases with varied completion and ready rates then check that every flagged job appears exactly once and that every unflagged job never appears.

// File: rtl/cq_pkg.sv
package cq_pkg;

  // per-slot state bits
  typedef struct packed {
    logic used;   // slot holds a job
    logic done;   // data mover finished the job
    logic ser;    // status record still owed
  } cq_flags_t;

endpackage

// File: rtl/cq_pick.sv
module cq_pick #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] idx,
  output logic                 any
);

  localparam int IW = $clog2(N);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pri
    assign gnt[g]     = req[g] & ~taken[g];
    assign taken[g+1] = taken[g] | req[g];
  end

  assign any = taken[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = idx | IW'(i);
    end
  end

  // R5: never more than one slot chosen
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R5: something chosen whenever something asks
  p_grant_when_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

endmodule

// File: rtl/cq_store.sv
module cq_store
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAGW  = 8,
  parameter int QIDW  = 3,
  parameter int AW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_en,
  input  logic                        alloc_ser,
  input  logic [TAGW-1:0]             alloc_tag,
  input  logic [QIDW-1:0]             alloc_qid,
  input  logic [AW-1:0]               alloc_addr,
  input  logic                        done_valid,
  input  logic [TAGW-1:0]             done_tag,
  input  logic                        clr_en,
  input  logic [$clog2(DEPTH)-1:0]    clr_idx,
  output logic [DEPTH-1:0]            used_o,
  output logic [DEPTH-1:0]            done_o,
  output logic [DEPTH-1:0]            ser_o,
  output logic [DEPTH-1:0][TAGW-1:0]  tag_o,
  output logic [DEPTH-1:0][QIDW-1:0]  qid_o,
  output logic [DEPTH-1:0][AW-1:0]    addr_o,
  output logic [$clog2(DEPTH+1)-1:0]  cnt_o,
  output logic                        shift_o
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  cq_flags_t        flg_q [DEPTH];
  cq_flags_t        upd   [DEPTH];
  cq_flags_t        flg_d [DEPTH];
  logic [TAGW-1:0]  tag_q [DEPTH];
  logic [QIDW-1:0]  qid_q [DEPTH];
  logic [AW-1:0]    addr_q[DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    wr_idx;
  logic             shift;

  // head leaves when finished and nothing is owed
  assign shift  = flg_q[0].used & flg_q[0].done & ~flg_q[0].ser;
  assign wr_idx = IW'(cnt_q - CW'(shift));
  assign cnt_d  = cnt_q - CW'(shift) + CW'(alloc_en);

  // completion marking and flag clear act on the pre-shift image,
  // so a clear aimed at slot k follows the job when it moves to k-1
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      upd[i] = flg_q[i];
      if (done_valid && flg_q[i].used && (tag_q[i] == done_tag)) upd[i].done = 1'b1;
      if (clr_en && (clr_idx == IW'(i))) upd[i].ser = 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    cq_flags_t       above;
    logic [TAGW-1:0] tag_above;
    logic [QIDW-1:0] qid_above;
    logic [AW-1:0]   addr_above;
    logic            here;
    logic            we;
    logic [TAGW-1:0] tag_d;
    logic [QIDW-1:0] qid_d;
    logic [AW-1:0]   addr_d;

    if (g == DEPTH - 1) begin : g_top
      assign above      = '0;
      assign tag_above  = '0;
      assign qid_above  = '0;
      assign addr_above = '0;
    end else begin : g_mid
      assign above      = upd[g+1];
      assign tag_above  = tag_q[g+1];
      assign qid_above  = qid_q[g+1];
      assign addr_above = addr_q[g+1];
    end

    assign here = alloc_en && (wr_idx == IW'(g));
    assign we   = here | shift;

    always_comb begin
      if (here) begin
        flg_d[g] = '{used: 1'b1, done: 1'b0, ser: alloc_ser};
        tag_d    = alloc_tag;
        qid_d    = alloc_qid;
        addr_d   = alloc_addr;
      end else if (shift) begin
        flg_d[g] = above;
        tag_d    = tag_above;
        qid_d    = qid_above;
        addr_d   = addr_above;
      end else begin
        flg_d[g] = upd[g];
        tag_d    = tag_q[g];
        qid_d    = qid_q[g];
        addr_d   = addr_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q[g] <= '0;
      else        flg_q[g] <= flg_d[g];
    end

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q[g]  <= tag_d;
        qid_q[g]  <= qid_d;
        addr_q[g] <= addr_d;
      end
    end

    assign used_o[g] = flg_q[g].used;
    assign done_o[g] = flg_q[g].done;
    assign ser_o[g]  = flg_q[g].ser;
    assign tag_o[g]  = tag_q[g];
    assign qid_o[g]  = qid_q[g];
    assign addr_o[g] = addr_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign shift_o = shift;

  // R2: occupancy moves by at most one per cycle
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) <= 32'($past(cnt_q)) + 1) && (32'(cnt_q) + 1 >= 32'($past(cnt_q))));

  // R8: held slots stay packed at the head
  p_packed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'($countones(used_o))));

endmodule

// File: rtl/cq_status_queue.sv
module cq_status_queue #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 8,
  parameter int QIDW  = 3,
  parameter int AW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic            alloc_ser,
  input  logic [TAGW-1:0] alloc_tag,
  input  logic [QIDW-1:0] alloc_qid,
  input  logic [AW-1:0]   alloc_addr,
  output logic            full,
  input  logic            done_valid,
  input  logic [TAGW-1:0] done_tag,
  output logic            st_valid,
  input  logic            st_ready,
  output logic [TAGW-1:0] st_tag,
  output logic [QIDW-1:0] st_qid,
  output logic [AW-1:0]   st_addr
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]           used, done, ser, elig, gnt;
  logic [DEPTH-1:0][TAGW-1:0] tag_a;
  logic [DEPTH-1:0][QIDW-1:0] qid_a;
  logic [DEPTH-1:0][AW-1:0]   addr_a;
  logic [CW-1:0]              cnt;
  logic                       shift, alloc_en, send;
  logic [IW-1:0]              sel_idx;
  logic                       clr_pend_q, clr_pend_d;
  logic [IW-1:0]              clr_idx_q, clr_idx_d;

  assign full     = (cnt == CW'(DEPTH));
  assign alloc_en = alloc_valid & ~full;

  cq_store #(
    .DEPTH (DEPTH),
    .TAGW  (TAGW),
    .QIDW  (QIDW),
    .AW    (AW)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_ser  (alloc_ser),
    .alloc_tag  (alloc_tag),
    .alloc_qid  (alloc_qid),
    .alloc_addr (alloc_addr),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .clr_en     (clr_pend_q),
    .clr_idx    (clr_idx_q),
    .used_o     (used),
    .done_o     (done),
    .ser_o      (ser),
    .tag_o      (tag_a),
    .qid_o      (qid_a),
    .addr_o     (addr_a),
    .cnt_o      (cnt),
    .shift_o    (shift)
  );

  // a slot whose clear is still in flight is masked from selection
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = used[i] & done[i] & ser[i] & ~(clr_pend_q && (clr_idx_q == IW'(i)));
    end
  end

  cq_pick #(.N(DEPTH)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .gnt   (gnt),
    .idx   (sel_idx),
    .any   (st_valid)
  );

  assign st_tag  = tag_a[sel_idx];
  assign st_qid  = qid_a[sel_idx];
  assign st_addr = addr_a[sel_idx];
  assign send    = st_valid & st_ready;

  // the clear lands next cycle; if the head leaves now, aim one lower
  always_comb begin
    clr_pend_d = send;
    clr_idx_d  = clr_idx_q;
    if (send) clr_idx_d = shift ? (sel_idx - IW'(1)) : sel_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_pend_q <= 1'b0;
      clr_idx_q  <= '0;
    end else begin
      clr_pend_q <= clr_pend_d;
      clr_idx_q  <= clr_idx_d;
    end
  end

  // R1: nothing offered from an empty queue
  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !st_valid);

  // R3: a refused request cannot grow the queue
  p_no_grow_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt <= $past(cnt)));

  // R7: an accepted record is not offered in the next cycle
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> !(st_valid && (st_tag == $past(st_tag))));

  // R9: a head that leaves is never the slot being sent
  p_send_not_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (send && shift) |-> (sel_idx != '0));

endmodule

// File: tb/tb_cq_status_queue.sv
module tb_cq_status_queue;

  localparam int DEPTH = 8;
  localparam int TAGW  = 8;
  localparam int QIDW  = 3;
  localparam int AW    = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            alloc_valid, alloc_ser;
  logic [TAGW-1:0] alloc_tag;
  logic [QIDW-1:0] alloc_qid;
  logic [AW-1:0]   alloc_addr;
  logic            full;
  logic            done_valid;
  logic [TAGW-1:0] done_tag;
  logic            st_valid, st_ready;
  logic [TAGW-1:0] st_tag;
  logic [QIDW-1:0] st_qid;
  logic [AW-1:0]   st_addr;

  always #2.5 clk = ~clk;

  cq_status_queue #(.DEPTH(DEPTH), .TAGW(TAGW), .QIDW(QIDW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ser(alloc_ser), .alloc_tag(alloc_tag),
    .alloc_qid(alloc_qid), .alloc_addr(alloc_addr), .full(full),
    .done_valid(done_valid), .done_tag(done_tag),
    .st_valid(st_valid), .st_ready(st_ready), .st_tag(st_tag),
    .st_qid(st_qid), .st_addr(st_addr)
  );

  int checks = 0, errors = 0;
  int m_checks = 0, m_errors = 0;
  bit wd_fail = 0;
  bit reported = 0;

  // monitor-owned model, one record per tag
  bit              m_live [256];
  bit              m_ser  [256];
  bit              m_done [256];
  int              m_got  [256];
  logic [QIDW-1:0] m_qid  [256];
  logic [AW-1:0]   m_addr [256];

  // driver-owned list of accepted, unfinished tags
  int pend [256];
  int npend = 0;

  function automatic logic [QIDW-1:0] qid_of(int t);
    return QIDW'(t * 5 + 1);
  endfunction

  function automatic logic [AW-1:0] addr_of(int t);
    return 32'h1000_0000 + AW'(t) * 32'h40;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (st_valid && st_ready) begin
        m_checks++;
        if (!(m_live[st_tag] && m_ser[st_tag] && m_done[st_tag] && m_got[st_tag] == 0 &&
              m_qid[st_tag] == st_qid && m_addr[st_tag] == st_addr)) begin
          m_errors++;
          $display("FAIL R7/R6/R4 record tag %0d qid %0d addr %h got %0d, expected one new finished flagged record qid %0d addr %h",
                   st_tag, st_qid, st_addr, m_got[st_tag], m_qid[st_tag], m_addr[st_tag]);
        end
        m_got[st_tag]++;
      end
      if (done_valid && m_live[done_tag]) m_done[done_tag] = 1'b1;
      if (alloc_valid && !full) begin
        m_live[alloc_tag] = 1'b1;
        m_ser[alloc_tag]  = alloc_ser;
        m_done[alloc_tag] = 1'b0;
        m_got[alloc_tag]  = 0;
        m_qid[alloc_tag]  = alloc_qid;
        m_addr[alloc_tag] = alloc_addr;
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks + m_checks + (wd_fail ? 1 : 0),
               errors + m_errors + (wd_fail ? 1 : 0));
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: run did not end, actual hung, expected completion");
    report();
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pend_drop(int t);
    for (int k = 0; k < npend; k++) begin
      if (pend[k] == t) begin
        pend[k] = pend[npend-1];
        npend--;
        break;
      end
    end
  endtask

  task automatic alloc1(int t, bit s);
    alloc_valid = 1'b1;
    alloc_ser   = s;
    alloc_tag   = TAGW'(t);
    alloc_qid   = qid_of(t);
    alloc_addr  = addr_of(t);
    if (!full) begin
      pend[npend] = t;
      npend++;
    end
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic done1(int t);
    done_valid = 1'b1;
    done_tag   = TAGW'(t);
    pend_drop(t);
    tick();
    done_valid = 1'b0;
  endtask

  task automatic drain();
    st_ready = 1'b1;
    while (npend > 0) done1(pend[0]);
    repeat (40) tick();
    chk(full == 1'b0, "R3 full after drain", full, 0);
    chk(st_valid == 1'b0, "R7 quiet after drain", st_valid, 0);
  endtask

  task automatic verify_tag(int t);
    chk(m_got[t] == (m_ser[t] ? 1 : 0), m_ser[t] ? "R7 once per flagged job" : "R8 no record unflagged",
        m_got[t], m_ser[t] ? 1 : 0);
  endtask

  task automatic rand_phase(int done_pct, int ready_pct);
    int nxt = 0;
    while (nxt < 128) begin
      done_valid = 1'b0;
      if (npend > 0 && ($urandom % 100) < done_pct) begin
        int k = int'($urandom % npend);
        done_valid = 1'b1;
        done_tag   = TAGW'(pend[k]);
        pend_drop(pend[k]);
      end
      alloc_valid = ($urandom % 2) == 1;
      alloc_ser   = ($urandom % 4) != 0;
      alloc_tag   = TAGW'(nxt);
      alloc_qid   = QIDW'($urandom);
      alloc_addr  = $urandom;
      if (alloc_valid && !full) begin
        pend[npend] = nxt;
        npend++;
        nxt++;
      end
      st_ready = ($urandom % 100) < ready_pct;
      tick();
    end
    alloc_valid = 1'b0;
    done_valid  = 1'b0;
    drain();
    for (int t = 0; t < 128; t++) verify_tag(t);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    alloc_valid = 0; alloc_ser = 0; alloc_tag = 0; alloc_qid = 0; alloc_addr = 0;
    done_valid = 0; done_tag = 0; st_ready = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(st_valid == 1'b0, "R1 st_valid after reset", st_valid, 0);

    // R2/R3 fill to capacity; tag 12 owes no record
    for (int t = 10; t < 18; t++) alloc1(t, t != 12);
    chk(full == 1'b1, "R3 full at capacity", full, 1);
    chk(st_valid == 1'b0, "R4 no record before completion", st_valid, 0);
    alloc1(200, 1'b1);
    chk(full == 1'b1, "R3 refused request keeps full", full, 1);

    // R10 unknown completion tag
    st_ready = 1'b1;
    done1(99);
    chk(st_valid == 1'b0, "R10 stray completion offers nothing", st_valid, 0);
    chk(full == 1'b1, "R10 stray completion frees nothing", full, 1);
    st_ready = 1'b0;

    // R5 ordering: finish a younger job first
    done1(15);
    chk(st_valid && st_tag == 15, "R4 finished job offered", st_tag, 15);
    done1(13);
    chk(st_valid && st_tag == 13, "R5 oldest eligible first", st_tag, 13);
    chk(st_qid == qid_of(13), "R6 queue id in record", st_qid, qid_of(13));
    chk(st_addr == addr_of(13), "R6 address in record", st_addr, addr_of(13));
    st_ready = 1'b1;
    tick();
    st_ready = 1'b0;
    chk(st_valid && st_tag == 15, "R7 sent job not reoffered", st_tag, 15);
    tick();
    chk(st_valid && st_tag == 15, "R7 still next job after clear", st_tag, 15);
    drain();
    for (int t = 10; t < 18; t++) verify_tag(t);
    chk(m_got[200] == 0, "R3 refused job produced no record", m_got[200], 0);

    // R9 variant 1: head leaves on the send cycle
    alloc1(30, 1'b0);
    alloc1(31, 1'b1);
    alloc1(32, 1'b1);
    done1(31);
    chk(st_valid && st_tag == 31, "R9 flagged job offered", st_tag, 31);
    done1(30);
    st_ready = 1'b1;
    tick();
    st_ready = 1'b0;
    chk(st_valid == 1'b0, "R9 send with shift, no repeat", st_valid, 0);
    repeat (3) tick();
    chk(st_valid == 1'b0, "R9 send with shift, still quiet", st_valid, 0);
    done1(32);
    chk(st_valid && st_tag == 32, "R9 next job intact after shift", st_tag, 32);
    drain();
    for (int t = 30; t < 33; t++) verify_tag(t);

    // R9 variant 2: head leaves on the clear cycle
    alloc1(40, 1'b0);
    alloc1(41, 1'b1);
    alloc1(42, 1'b1);
    done1(41);
    done_valid = 1'b1;
    done_tag   = 8'd40;
    pend_drop(40);
    st_ready = 1'b1;
    tick();
    done_valid = 1'b0;
    st_ready = 1'b0;
    tick();
    chk(st_valid == 1'b0, "R9 clear with shift, no repeat", st_valid, 0);
    repeat (3) tick();
    chk(st_valid == 1'b0, "R9 clear with shift, still quiet", st_valid, 0);
    done1(42);
    chk(st_valid && st_tag == 42, "R9 next job intact after clear", st_tag, 42);
    drain();
    for (int t = 40; t < 43; t++) verify_tag(t);

    // random phases with varied completion and ready rates
    rand_phase(40, 60);
    rand_phase(80, 30);
    rand_phase(20, 90);
    rand_phase(100, 100);

    report();
  end

endmodule